// File: doc/BRIEF.md
# Timer with Shared Prescaler and Watchdog

This block holds an 8-bit up-counter and a watchdog counter that share one 8-bit binary prescaler. A routing bit decides who owns the prescaler. When the timer owns it, the prescaler divides the timer's count source. When the watchdog owns it, the prescaler divides the watchdog's base tick, and the timer counts its source undivided. The timer's source is either the instruction-cycle clock, which is `clk` itself, or an external pin. The pin is first XORed with a polarity bit, then taken through a two-stage synchronizer and an edge detector.

When the timer wraps from its maximum value to zero it raises a one-cycle pulse for the interrupt logic. Software can load the timer at any time. A load clears the timer-side prescaler and freezes the count path for two cycles. A watchdog clear restarts the watchdog. When the watchdog owns the prescaler, the clear restarts the prescaler as well. When the watchdog counter wraps, it gives a one-cycle time-out pulse.

Top module: `tick_timer_wdog`

## Requirements
- R1: While `rst_n` is low, `tmr_q` is 0, `tmr_ovf` is 0 and `wdt_timeout` is 0.
- R2: With `src_ext`=0 and `route_wdt`=1, `tmr_q` rises by one on every clock edge once the load freeze has ended.
- R3: With `src_ext`=1 and `edge_fall`=0, every 0-to-1 change of `ext_clk` raises `tmr_q` by one on the third clock edge after the change. A steady pin, or a 1-to-0 change, leaves `tmr_q` unchanged.
- R4: With `edge_fall`=1, the timer counts the 1-to-0 changes of `ext_clk` with the same three-edge latency. A 0-to-1 change is ignored. If the pin and `edge_fall` toggle together, no count results.
- R5: With `route_wdt`=0, the timer advances once per 2^(`ps_sel`+1) source ticks. With `ps_sel`=2 this is once every 8 cycles.
- R6: A load (`tmr_wr`=1) puts `tmr_wdata` in `tmr_q` on that edge. When `route_wdt`=0 it also clears the prescaler. The two edges that follow perform no count and do not advance the prescaler.
- R7: `tmr_ovf` is high for exactly one cycle, the cycle in which a count moves `tmr_q` from 8'hFF to 8'h00. A load never raises it.
- R8: With `route_wdt`=0, the 8-bit watchdog counter advances on every edge. `wdt_timeout` pulses for one cycle 256 edges after the clear edge.
- R9: With `route_wdt`=1, the watchdog advances once per 2^`ps_sel` cycles. With `ps_sel`=1, `wdt_timeout` pulses 512 edges after the clear edge.
- R10: `wdt_clr` restarts the watchdog counter. When `route_wdt`=1 it also restarts the prescaler. When `route_wdt`=0 it leaves the timer's prescaled count timing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_ext | input | 1 | 0: count cycles, 1: count the external pin |
| edge_fall | input | 1 | 1: count pin falling edges |
| route_wdt | input | 1 | 1: prescaler serves the watchdog |
| ps_sel | input | 3 | Prescaler tap select |
| ext_clk | input | 1 | External count pin (asynchronous) |
| tmr_wr | input | 1 | Timer load strobe |
| tmr_wdata | input | 8 | Timer load value |
| wdt_clr | input | 1 | Watchdog clear |
| tmr_q | output | 8 | Timer value |
| tmr_ovf | output | 1 | Wrap pulse |
| wdt_timeout | output | 1 | Watchdog time-out pulse |

## Verification
The hardest case to produce is a change of polarity that must not count. The bench reaches it by raising `ext_clk` and `edge_fall` in the same cycle, so the XORed level stays constant. It then confirms that the timer stays put through the whole synchronizer latency. The watchdog windows are long, so the bench clears the counter on a known edge. It then counts exactly 255 or 511 quiet edges before it expects the single pulse, both with the prescaler routed to the timer and with it routed to the watchdog.

// File: rtl/tick_pkg.sv
package tick_pkg;
   typedef enum logic {
      ROUTE_TMR = 1'b0,
      ROUTE_WDT = 1'b1
   } route_e;
endpackage

// File: rtl/tick_src_sel.sv
module tick_src_sel #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_ext,
   input  logic edge_fall,
   input  logic ext_clk,
   output logic src_pulse
);
   logic [SYNC_STAGES-1:0] chain;
   logic                   prev;
   logic                   pin_pol;
   logic                   ext_rise;

   assign pin_pol = ext_clk ^ edge_fall;

   genvar gi;
   generate
      for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n)
               chain[gi] <= 1'b0;
            else if (gi == 0)
               chain[gi] <= pin_pol;
            else
               chain[gi] <= chain[(gi == 0) ? 0 : gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= chain[SYNC_STAGES-1];
   end

   assign ext_rise  = chain[SYNC_STAGES-1] & ~prev;
   assign src_pulse = src_ext ? ext_rise : 1'b1;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (src_ext && src_pulse) |=> !src_pulse || !src_ext); // R3
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
   import tick_pkg::*;
#(
   parameter int PS_W  = 8,
   parameter int SEL_W = $clog2(PS_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  route_e           route,
   input  logic [SEL_W-1:0] sel,
   input  logic             src_pulse,
   input  logic             hold,
   input  logic             clr_tmr,
   input  logic             clr_wdt,
   output logic             tmr_pulse,
   output logic             wd_tick
);
   logic [PS_W-1:0] pcnt;
   logic [PS_W-1:0] mask_t;
   logic [PS_W-1:0] mask_w;
   logic            advance;

   always_comb begin
      for (int i = 0; i < PS_W; i++) begin
         mask_t[i] = (i <= int'(sel));
         mask_w[i] = (i < int'(sel));
      end
   end

   always_comb begin
      if (route == ROUTE_TMR) begin
         advance   = src_pulse & ~hold;
         tmr_pulse = advance & ((pcnt & mask_t) == mask_t);
         wd_tick   = 1'b1;
      end else begin
         advance   = 1'b1;
         tmr_pulse = src_pulse;
         wd_tick   = ((pcnt & mask_w) == mask_w);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         pcnt <= '0;
      else if ((route == ROUTE_TMR && clr_tmr) || (route == ROUTE_WDT && clr_wdt))
         pcnt <= '0;
      else if (advance)
         pcnt <= pcnt + 1'b1;
   end

   AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (route == ROUTE_TMR && hold && !clr_tmr) |=> $stable(pcnt)); // R6
   AST_WDT_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (route == ROUTE_WDT && clr_wdt) |=> (pcnt == '0) || (route == ROUTE_TMR)); // R10
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
   parameter int TMR_W       = 8,
   parameter int INHIBIT_CYC = 2,
   localparam int INH_W      = $clog2(INHIBIT_CYC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cnt_pulse,
   input  logic             wr,
   input  logic [TMR_W-1:0] wdata,
   output logic [TMR_W-1:0] q,
   output logic             ovf,
   output logic             frozen
);
   logic [INH_W-1:0] inhib;
   logic             inc;

   assign frozen = (inhib != '0);
   assign inc    = cnt_pulse & ~frozen & ~wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q     <= '0;
         ovf   <= 1'b0;
         inhib <= '0;
      end else if (wr) begin
         q     <= wdata;
         ovf   <= 1'b0;
         inhib <= INH_W'(INHIBIT_CYC);
      end else begin
         if (frozen) inhib <= inhib - 1'b1;
         if (inc)    q     <= q + 1'b1;
         ovf <= inc && (q == '1);
      end
   end

   AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> !ovf); // R7
   AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> (q == '0)); // R7
   AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (q == $past(wdata))); // R6
   AST_WR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(wr) && !wr) |=> $stable(q)); // R6
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> (q == $past(q)) || (q == $past(q) + TMR_W'(1))); // R2
endmodule

// File: rtl/tick_wdog.sv
module tick_wdog #(
   parameter int WDT_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic clr,
   output logic timeout
);
   logic [WDT_W-1:0] wcnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wcnt    <= '0;
         timeout <= 1'b0;
      end else if (tick) begin
         wcnt    <= wcnt + 1'b1;
         timeout <= (wcnt == '1);
      end else begin
         timeout <= 1'b0;
      end
   end

   AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      timeout |=> !timeout); // R8
   AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !timeout); // R10
endmodule

// File: rtl/tick_timer_wdog.sv
module tick_timer_wdog
   import tick_pkg::*;
#(
   parameter int TMR_W       = 8,
   parameter int PS_W        = 8,
   parameter int WDT_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int INHIBIT_CYC = 2,
   localparam int SEL_W      = $clog2(PS_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_ext,
   input  logic             edge_fall,
   input  logic             route_wdt,
   input  logic [SEL_W-1:0] ps_sel,
   input  logic             ext_clk,
   input  logic             tmr_wr,
   input  logic [TMR_W-1:0] tmr_wdata,
   input  logic             wdt_clr,
   output logic [TMR_W-1:0] tmr_q,
   output logic             tmr_ovf,
   output logic             wdt_timeout
);
   initial begin
      assert (PS_W == (1 << SEL_W)) else $fatal(1, "PS_W must be a power of two");
      assert (TMR_W >= 2)           else $fatal(1, "TMR_W too small");
      assert (WDT_W >= 1)           else $fatal(1, "WDT_W too small");
      assert (SYNC_STAGES >= 2)     else $fatal(1, "SYNC_STAGES below 2");
      assert (INHIBIT_CYC >= 1)     else $fatal(1, "INHIBIT_CYC below 1");
   end

   route_e route;
   logic   src_pulse;
   logic   tmr_pulse;
   logic   wd_tick;
   logic   frozen;

   assign route = route_wdt ? ROUTE_WDT : ROUTE_TMR;

   tick_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_ext   (src_ext),
      .edge_fall (edge_fall),
      .ext_clk   (ext_clk),
      .src_pulse (src_pulse)
   );

   tick_prescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_ps (
      .clk       (clk),
      .rst_n     (rst_n),
      .route     (route),
      .sel       (ps_sel),
      .src_pulse (src_pulse),
      .hold      (frozen),
      .clr_tmr   (tmr_wr),
      .clr_wdt   (wdt_clr),
      .tmr_pulse (tmr_pulse),
      .wd_tick   (wd_tick)
   );

   tick_timer #(.TMR_W(TMR_W), .INHIBIT_CYC(INHIBIT_CYC)) u_tmr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_pulse (tmr_pulse),
      .wr        (tmr_wr),
      .wdata     (tmr_wdata),
      .q         (tmr_q),
      .ovf       (tmr_ovf),
      .frozen    (frozen)
   );

   tick_wdog #(.WDT_W(WDT_W)) u_wdt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (wd_tick),
      .clr     (wdt_clr),
      .timeout (wdt_timeout)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (tmr_q == '0) && !tmr_ovf && !wdt_timeout); // R1
endmodule

// File: tb/tick_timer_wdog_tb.sv
module tick_timer_wdog_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       src_ext = 1'b0, edge_fall = 1'b0, route_wdt = 1'b0;
   logic [2:0] ps_sel = 3'd0;
   logic       ext_clk = 1'b0, tmr_wr = 1'b0, wdt_clr = 1'b0;
   logic [7:0] tmr_wdata = 8'h00;
   logic [7:0] tmr_q;
   logic       tmr_ovf, wdt_timeout;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   string      q_req[$];
   int         q_sel[$];
   logic [7:0] q_exp[$];

   always #10 clk = ~clk;

   tick_timer_wdog u_dut (
      .clk(clk), .rst_n(rst_n), .src_ext(src_ext), .edge_fall(edge_fall),
      .route_wdt(route_wdt), .ps_sel(ps_sel), .ext_clk(ext_clk),
      .tmr_wr(tmr_wr), .tmr_wdata(tmr_wdata), .wdt_clr(wdt_clr),
      .tmr_q(tmr_q), .tmr_ovf(tmr_ovf), .wdt_timeout(wdt_timeout)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // driver side: queue the value an output must hold after the last edge
   task automatic expect_out(input string req, input int sel, input logic [7:0] exp);
      q_req.push_back(req);
      q_sel.push_back(sel);
      q_exp.push_back(exp);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // monitor side: compares queued items away from the active edge
   always @(negedge clk) begin
      cycles++;
      while (q_req.size() > 0) begin
         string      r;
         int         s;
         logic [7:0] e;
         logic [7:0] got;
         r = q_req.pop_front();
         s = q_sel.pop_front();
         e = q_exp.pop_front();
         got = (s == 0) ? tmr_q : (s == 1) ? {7'd0, tmr_ovf} : {7'd0, wdt_timeout};
         n_checks++;
         if (got !== e) begin
            n_fail++;
            $display("FAIL %s: output %0d actual %h expected %h", r, s, got, e);
         end
      end
      if (cycles > 200000) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
      end
   end

   initial begin
      repeat (3) step();
      expect_out("R1", 0, 8'h00);
      expect_out("R1", 1, 8'h00);
      expect_out("R1", 2, 8'h00);
      step();
      rst_n = 1'b1;
      step();

      // R2 / R7: direct internal counting and wrap
      route_wdt = 1'b1; src_ext = 1'b0; ps_sel = 3'd7;
      tmr_wr = 1'b1; tmr_wdata = 8'hFD;
      step();
      expect_out("R6", 0, 8'hFD); expect_out("R7", 1, 8'h00);
      tmr_wr = 1'b0;
      step(); expect_out("R6", 0, 8'hFD);
      step(); expect_out("R6", 0, 8'hFD);
      step(); expect_out("R2", 0, 8'hFE);
      step(); expect_out("R2", 0, 8'hFF); expect_out("R7", 1, 8'h00);
      step(); expect_out("R7", 0, 8'h00); expect_out("R7", 1, 8'h01);
      step(); expect_out("R2", 0, 8'h01); expect_out("R7", 1, 8'h00);
      step(); expect_out("R2", 0, 8'h02);

      // R7: loading FF gives no pulse, later wrap does
      tmr_wr = 1'b1; tmr_wdata = 8'hFF;
      step(); expect_out("R7", 1, 8'h00); expect_out("R6", 0, 8'hFF);
      tmr_wr = 1'b0;
      step(); expect_out("R7", 1, 8'h00);
      step(); expect_out("R6", 0, 8'hFF);
      step(); expect_out("R7", 0, 8'h00); expect_out("R7", 1, 8'h01);

      // R3: external rising edges
      src_ext = 1'b1; edge_fall = 1'b0; ext_clk = 1'b0;
      tmr_wr = 1'b1; tmr_wdata = 8'h40;
      step();
      tmr_wr = 1'b0;
      repeat (4) step();
      expect_out("R3", 0, 8'h40);
      ext_clk = 1'b1;
      step(); expect_out("R3", 0, 8'h40);
      step(); expect_out("R3", 0, 8'h40);
      step(); expect_out("R3", 0, 8'h41);
      repeat (4) step(); expect_out("R3", 0, 8'h41);
      ext_clk = 1'b0;
      repeat (5) step(); expect_out("R3", 0, 8'h41);

      // R4: polarity change together with pin change, then falling edge
      ext_clk = 1'b1; edge_fall = 1'b1;
      repeat (5) step(); expect_out("R4", 0, 8'h41);
      ext_clk = 1'b0;
      step(); step(); expect_out("R4", 0, 8'h41);
      step(); expect_out("R4", 0, 8'h42);
      ext_clk = 1'b1;
      repeat (5) step(); expect_out("R4", 0, 8'h42);

      // R5 / R6: prescaler in front of timer, 1:8
      src_ext = 1'b0; edge_fall = 1'b0; ext_clk = 1'b0;
      route_wdt = 1'b0; ps_sel = 3'd2;
      tmr_wr = 1'b1; tmr_wdata = 8'h10;
      step();
      tmr_wr = 1'b0;
      repeat (9) step(); expect_out("R5", 0, 8'h10);
      step();            expect_out("R5", 0, 8'h11);
      repeat (7) step(); expect_out("R5", 0, 8'h11);
      step();            expect_out("R5", 0, 8'h12);

      // R10: watchdog clear leaves timer-side prescaler alone
      tmr_wr = 1'b1; tmr_wdata = 8'h20;
      step();
      tmr_wr = 1'b0;
      repeat (4) step();
      wdt_clr = 1'b1;
      step();
      wdt_clr = 1'b0;
      repeat (4) step(); expect_out("R10", 0, 8'h20);
      step();            expect_out("R10", 0, 8'h21);

      // R8: watchdog unscaled
      wdt_clr = 1'b1;
      step();
      wdt_clr = 1'b0;
      repeat (255) step(); expect_out("R8", 2, 8'h00);
      step();              expect_out("R8", 2, 8'h01);
      step();              expect_out("R8", 2, 8'h00);

      // R9 / R10: prescaler behind watchdog, 1:2, clear restarts both
      route_wdt = 1'b1; ps_sel = 3'd1; wdt_clr = 1'b1;
      step();
      wdt_clr = 1'b0;
      repeat (511) step(); expect_out("R9", 2, 8'h00);
      step();              expect_out("R9", 2, 8'h01);
      step();              expect_out("R9", 2, 8'h00);

      step();
      step();
      summary();
   end
endmodule